// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and presents a single interrupt output to a processor. Each line is captured into a pending-request register. A mask register decides which pending lines may compete, and an in-service register records the lines whose handlers are still running. A priority resolver picks the winning pending line under one of three orderings: fixed, a software-chosen lowest line, or a rotation that moves each retired line to the bottom.

The processor answers the interrupt output with a one-cycle acknowledge strobe. In that same cycle the block returns a vector, equal to a programmable base plus the line index, and moves the winner from pending to in-service. Service ends in one of three ways: a specific end-of-interrupt command that names the line, a non-specific command that retires the highest-ranked in-service line, or automatic retirement at acknowledge. Because a line of higher rank can raise the output while a lower one is in service, handlers can nest.

A small register port, with address, write strobe, write data and combinational read data, carries all configuration and the end-of-interrupt commands.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register (address 0) reads 0xFF, the trigger register (address 1) reads 0x00, the control register (address 2) reads 0x00, the vector base (address 3) reads 0x00, the pending (address 6) and in-service (address 7) registers read 0x00, and int_o is low.
- R2: For a line whose trigger bit is 0 (edge), a rising transition of the line sets its pending bit. The bit stays set until that line is acknowledged. A line that is still held high after acknowledge does not set the bit again.
- R3: For a line whose trigger bit is 1 (level), the pending bit follows the synchronised level. It is cleared by acknowledge and comes back on the next cycle if the line is still high, and it clears when the line falls.
- R4: A pending line whose mask bit is 1 never raises int_o and is never acknowledged. Clearing the mask bit lets the line raise int_o.
- R5: In fixed priority mode (control bits [1:0] = 0), line 0 ranks highest and line 7 lowest.
- R6: An acknowledge while int_o is high drives vec_o = base + winning index in the same cycle. On that edge it clears the winner's pending bit and sets its in-service bit.
- R7: int_o is high only when the best unmasked pending line strictly outranks every set in-service bit. A higher line nests over a lower one, and a line of equal or lower rank waits. A single line can hold one pending request and one in-service entry at the same time.
- R8: Writing address 5 with bit 7 = 0 (non-specific end-of-interrupt) clears the highest-ranked set in-service bit. Lines of equal or lower rank can then raise int_o.
- R9: Writing address 5 with bit 7 = 1 (specific end-of-interrupt) clears the in-service bit of the line given in bits [2:0].
- R10: With control bit 2 = 1 (automatic end-of-interrupt), an acknowledge returns the vector and clears the pending bit but leaves the in-service register unchanged.
- R11: In specific priority mode (control bits [1:0] = 1), the line written to address 4 ranks lowest and the line after it, counted modulo 8, ranks highest.
- R12: In rotating mode (control bits [1:0] = 2), each end-of-interrupt or automatic retirement makes the retired line the lowest. Address 4 reads back the current lowest line.
- R13: An acknowledge while int_o is low returns base + 7 and leaves the pending and in-service registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| ack_i | input | 1 | One-cycle acknowledge from the processor |
| vec_o | output | 8 | Vector returned during acknowledge |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets the rank comparison between pending and in-service bits. If that compare accepted equal rank, a level line still held high would re-raise int_o right after its own acknowledge, and a lower line would interrupt a higher handler. It drives an acknowledge with nothing eligible: a design that failed to gate it would set a random in-service bit or return the wrong vector. It also follows the lowest-line pointer through two rotations and a wrapped specific order. A modulo or update error there would pick the wrong winner from two simultaneous requests, which the bench sees in the returned vector.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    PRIO_FIXED = 2'd0,
    PRIO_SPEC  = 2'd1,
    PRIO_ROT   = 2'd2
  } prio_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd0;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_BASE = 3'd3;
  localparam logic [ADDR_W-1:0] A_LOW  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EOI  = 3'd5;
  localparam logic [ADDR_W-1:0] A_REQ  = 3'd6;
  localparam logic [ADDR_W-1:0] A_SVC  = 3'd7;
endpackage

// File: rtl/prio_irq_capture.sv
module prio_irq_capture #(
  parameter int N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] level_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [N_IRQ-1:0] irr_o
);
  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic s1_q, s2_q, dly_q, req_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        dly_q <= 1'b0;
        req_q <= 1'b0;
      end else begin
        s1_q  <= irq_i[g];
        s2_q  <= s1_q;
        dly_q <= s2_q;
        if (level_i[g]) req_q <= s2_q & ~clr_i[g];
        else            req_q <= (req_q & ~clr_i[g]) | (s2_q & ~dly_q);
      end
    end
    assign irr_o[g] = req_q;
  end
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] vec_i,
  input  logic [IDX_W-1:0] low_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] rank_o
);
  // rank 0 is the line just after low_i; scan downwards so the best rank wins
  always_comb begin
    int pos;
    found_o = 1'b0;
    idx_o   = '0;
    rank_o  = '0;
    pos     = 0;
    for (int r = N_IRQ - 1; r >= 0; r--) begin
      pos = (int'(low_i) + 1 + r) % N_IRQ;
      if (vec_i[pos]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(pos);
        rank_o  = IDX_W'(r);
      end
    end
  end
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [N_IRQ-1:0]  irr_i,
  input  logic [N_IRQ-1:0]  isr_i,
  input  logic              low_upd_i,
  input  logic [IDX_W-1:0]  low_val_i,
  output logic [N_IRQ-1:0]  mask_o,
  output logic [N_IRQ-1:0]  level_o,
  output prio_mode_e        prio_o,
  output logic              auto_o,
  output logic [VEC_W-1:0]  base_o,
  output logic [IDX_W-1:0]  low_o,
  output logic              eoi_ns_o,
  output logic              eoi_sp_o,
  output logic [IDX_W-1:0]  eoi_idx_o
);
  logic wr_mask, wr_trig, wr_ctrl, wr_base, wr_low, wr_eoi;
  assign wr_mask = wr_en_i && addr_i == A_MASK;
  assign wr_trig = wr_en_i && addr_i == A_TRIG;
  assign wr_ctrl = wr_en_i && addr_i == A_CTRL;
  assign wr_base = wr_en_i && addr_i == A_BASE;
  assign wr_low  = wr_en_i && addr_i == A_LOW;
  assign wr_eoi  = wr_en_i && addr_i == A_EOI;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= '1;
      level_o <= '0;
      prio_o  <= PRIO_FIXED;
      auto_o  <= 1'b0;
      base_o  <= '0;
      low_o   <= IDX_W'(N_IRQ - 1);
    end else begin
      if (wr_mask) mask_o  <= wdata_i[N_IRQ-1:0];
      if (wr_trig) level_o <= wdata_i[N_IRQ-1:0];
      if (wr_ctrl) begin
        prio_o <= (wdata_i[1:0] == 2'd3) ? PRIO_FIXED : prio_mode_e'(wdata_i[1:0]);
        auto_o <= wdata_i[2];
      end
      if (wr_base) base_o <= wdata_i[VEC_W-1:0];
      if (low_upd_i)   low_o <= low_val_i;
      else if (wr_low) low_o <= wdata_i[IDX_W-1:0];
    end
  end

  assign eoi_ns_o  = wr_eoi & ~wdata_i[7];
  assign eoi_sp_o  = wr_eoi &  wdata_i[7];
  assign eoi_idx_o = wdata_i[IDX_W-1:0];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_MASK:  rdata_o = 8'(mask_o);
      A_TRIG:  rdata_o = 8'(level_o);
      A_CTRL:  rdata_o = {5'd0, auto_o, prio_o};
      A_BASE:  rdata_o = 8'(base_o);
      A_LOW:   rdata_o = 8'(low_o);
      A_EOI:   rdata_o = '0;
      A_REQ:   rdata_o = 8'(irr_i);
      A_SVC:   rdata_o = 8'(isr_i);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              ack_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              int_o
);
  logic [N_IRQ-1:0] irr_q, isr_q, mask_q, level_q, ack_clr, eoi_clr, svc_set;
  prio_mode_e       prio_q;
  logic             auto_eoi, eoi_ns, eoi_sp, grant, low_upd;
  logic [VEC_W-1:0] base_q;
  logic [IDX_W-1:0] low_q, eff_low, eoi_idx, low_val;
  logic             w_found, s_found;
  logic [IDX_W-1:0] w_idx, w_rank, s_idx, s_rank;

  prio_irq_regs #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .irr_i(irr_q), .isr_i(isr_q), .low_upd_i(low_upd), .low_val_i(low_val),
    .mask_o(mask_q), .level_o(level_q), .prio_o(prio_q), .auto_o(auto_eoi),
    .base_o(base_q), .low_o(low_q), .eoi_ns_o(eoi_ns), .eoi_sp_o(eoi_sp),
    .eoi_idx_o(eoi_idx)
  );

  prio_irq_capture #(.N_IRQ(N_IRQ)) u_capture (
    .clk_i, .rst_ni, .irq_i, .level_i(level_q), .clr_i(ack_clr), .irr_o(irr_q)
  );

  assign eff_low = (prio_q == PRIO_FIXED) ? IDX_W'(N_IRQ - 1) : low_q;

  prio_irq_resolve #(.N_IRQ(N_IRQ)) u_pend_res (
    .vec_i(irr_q & ~mask_q), .low_i(eff_low),
    .found_o(w_found), .idx_o(w_idx), .rank_o(w_rank)
  );

  prio_irq_resolve #(.N_IRQ(N_IRQ)) u_svc_res (
    .vec_i(isr_q), .low_i(eff_low),
    .found_o(s_found), .idx_o(s_idx), .rank_o(s_rank)
  );

  // strict outrank: equal rank never nests over itself
  assign int_o = w_found & (~s_found | (w_rank < s_rank));
  assign grant = ack_i & int_o;
  assign vec_o = base_q + VEC_W'(grant ? w_idx : IDX_W'(N_IRQ - 1));

  always_comb begin
    ack_clr = '0;
    svc_set = '0;
    eoi_clr = '0;
    if (grant) begin
      ack_clr[w_idx] = 1'b1;
      svc_set[w_idx] = ~auto_eoi;
    end
    if (eoi_ns && s_found) eoi_clr[s_idx]   = 1'b1;
    if (eoi_sp)            eoi_clr[eoi_idx] = 1'b1;
  end

  always_comb begin
    low_upd = 1'b0;
    low_val = low_q;
    if (prio_q == PRIO_ROT) begin
      if (grant && auto_eoi) begin
        low_upd = 1'b1;
        low_val = w_idx;
      end else if (eoi_ns && s_found) begin
        low_upd = 1'b1;
        low_val = s_idx;
      end else if (eoi_sp) begin
        low_upd = 1'b1;
        low_val = eoi_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~eoi_clr) | svc_set;
  end
endmodule

// File: rtl/prio_irq_ctrl_sva.sv
module prio_irq_ctrl_sva #(
  parameter int N_IRQ = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             int_o,
  input logic             wr_en_i,
  input logic [2:0]       addr_i,
  input logic [N_IRQ-1:0] isr_q,
  input logic [N_IRQ-1:0] irr_q,
  input logic [N_IRQ-1:0] mask_q,
  input logic             auto_eoi
);
  logic eoi_wr;
  assign eoi_wr = wr_en_i && addr_i == 3'd5;

  assert_int_needs_unmasked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (irr_q & ~mask_q) != '0);

  assert_all_masked_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !int_o);

  assert_ack_enters_service_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && !auto_eoi && !eoi_wr)
    |=> $countones(isr_q) == $past($countones(isr_q)) + 1);

  assert_auto_keeps_service_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && auto_eoi && !eoi_wr) |=> $stable(isr_q));

  assert_spurious_no_service_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o && !eoi_wr) |=> $stable(isr_q));

  assert_eoi_never_adds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && !ack_i) |=> $countones(isr_q) <= $past($countones(isr_q)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_sva #(.N_IRQ(N_IRQ)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .int_o(int_o),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .isr_q(isr_q), .irr_q(irr_q),
  .mask_q(mask_q), .auto_eoi(auto_eoi)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_i = '0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ack_i = 1'b0;
  logic [7:0] vec_o;
  logic       int_o;

  int tests = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  prio_irq_ctrl dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ack(output logic [7:0] v);
    @(posedge clk_i); #1;
    ack_i = 1'b1;
    @(negedge clk_i);
    v = vec_o;
    @(posedge clk_i); #1;
    ack_i = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic chk_int(input string req, input int exp);
    @(negedge clk_i);
    chk(req, int_o, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 mask", 3'd0, 8'hFF);
    chk_reg("R1 trig", 3'd1, 8'h00);
    chk_reg("R1 ctrl", 3'd2, 8'h00);
    chk_reg("R1 base", 3'd3, 8'h00);
    chk_reg("R1 req",  3'd6, 8'h00);
    chk_reg("R1 svc",  3'd7, 8'h00);
    chk_int("R1 int", 0);
  endtask

  task automatic t_fixed_nest();
    logic [7:0] v;
    wr(3'd3, 8'h40);
    wr(3'd0, 8'h00);
    irq_i = 8'h24; cyc(4);
    chk_reg("R2 req set", 3'd6, 8'h24);
    chk_int("R5 int", 1);
    ack(v);
    chk("R5 R6 vector", v, 8'h42);
    chk_reg("R2 held high no rerequest", 3'd6, 8'h20);
    chk_reg("R6 svc", 3'd7, 8'h04);
    chk_int("R7 lower blocked", 0);
    wr(3'd5, 8'h00);
    chk_reg("R8 ns eoi", 3'd7, 8'h00);
    chk_int("R8 lower reallowed", 1);
    ack(v);
    chk("R6 vector 5", v, 8'h45);
    irq_i = 8'h00; cyc(3);
    irq_i = 8'h02; cyc(4);
    chk_int("R7 higher nests", 1);
    ack(v);
    chk("R7 nest vector", v, 8'h41);
    chk_reg("R7 svc nested", 3'd7, 8'h22);
    wr(3'd5, 8'h00);
    chk_reg("R8 highest cleared", 3'd7, 8'h20);
    wr(3'd5, 8'h85);
    chk_reg("R9 specific eoi", 3'd7, 8'h00);
    irq_i = 8'h00; cyc(4);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(3'd0, 8'h08);
    irq_i = 8'h08; cyc(4);
    chk_reg("R4 masked still pending", 3'd6, 8'h08);
    chk_int("R4 masked quiet", 0);
    wr(3'd0, 8'h00);
    chk_int("R4 unmasked raises", 1);
    ack(v);
    chk("R4 vector", v, 8'h43);
    wr(3'd5, 8'h00);
    irq_i = 8'h00; cyc(4);
  endtask

  task automatic t_level();
    logic [7:0] v;
    wr(3'd1, 8'h10);
    irq_i = 8'h10; cyc(4);
    chk_reg("R3 level pending", 3'd6, 8'h10);
    ack(v);
    chk("R3 vector", v, 8'h44);
    cyc(2);
    chk_reg("R3 R7 pending again", 3'd6, 8'h10);
    chk_reg("R7 one in service", 3'd7, 8'h10);
    chk_int("R7 equal rank blocked", 0);
    irq_i = 8'h00; cyc(4);
    chk_reg("R3 level falls", 3'd6, 8'h00);
    wr(3'd5, 8'h00);
    chk_int("R3 quiet", 0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_spurious();
    logic [7:0] v;
    ack(v);
    chk("R13 spurious vector", v, 8'h47);
    chk_reg("R13 svc unchanged", 3'd7, 8'h00);
    chk_reg("R13 req unchanged", 3'd6, 8'h00);
  endtask

  task automatic t_auto();
    logic [7:0] v;
    wr(3'd2, 8'h04);
    irq_i = 8'h40; cyc(4);
    ack(v);
    chk("R10 vector", v, 8'h46);
    chk_reg("R10 svc empty", 3'd7, 8'h00);
    chk_reg("R10 req cleared", 3'd6, 8'h00);
    wr(3'd2, 8'h00);
    irq_i = 8'h00; cyc(4);
  endtask

  task automatic t_specific();
    logic [7:0] v;
    wr(3'd2, 8'h01);
    wr(3'd4, 8'h02);
    irq_i = 8'h42; cyc(4);
    ack(v);
    chk("R11 wrapped winner", v, 8'h46);
    wr(3'd5, 8'h00);
    ack(v);
    chk("R11 second", v, 8'h41);
    wr(3'd5, 8'h00);
    irq_i = 8'h00; cyc(4);
  endtask

  task automatic t_rotate();
    logic [7:0] v;
    wr(3'd2, 8'h02);
    wr(3'd4, 8'h07);
    irq_i = 8'h09; cyc(4);
    ack(v);
    chk("R12 first", v, 8'h40);
    wr(3'd5, 8'h00);
    chk_reg("R12 low moved", 3'd4, 8'h00);
    ack(v);
    chk("R12 second", v, 8'h43);
    wr(3'd5, 8'h00);
    chk_reg("R12 low moved again", 3'd4, 8'h03);
    irq_i = 8'h00; cyc(4);
    irq_i = 8'h21; cyc(4);
    ack(v);
    chk("R12 rotated winner", v, 8'h45);
    wr(3'd5, 8'h00);
    irq_i = 8'h00; cyc(4);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_fixed_nest();
    t_mask();
    t_level();
    t_spurious();
    t_auto();
    t_specific();
    t_rotate();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule